// File: doc/BRIEF.md
# Facility Data Link Byte Receiver

This block collects the serial data-link bits that a T1 framer has already pulled out of the frame. One bit arrives per cycle on which `bitValid` is high. An optional zero-destuffer removes the zero a transmitter inserts after five ones in a row. The surviving bits are packed least significant bit first into bytes. Each finished byte is copied into a read register, so software sees a stable value while the next byte is still arriving.

At the link's nominal pace of one bit per 250 µs, a byte finishes every 2 ms. Software must read each byte within that window, or the next byte replaces it.

Every finished byte raises a sticky "byte ready" flag. The byte is also compared with two programmable match bytes, and a hit on either one raises a sticky "match" flag. Each flag has its own mask bit, and an unmasked flag pulls the active-low interrupt output low. A small register interface gives access to the byte, the flags, the control bits and the match bytes.

Top module: `fdlRecvTop`

## Requirements
- R1: Bits accepted into the byte are packed least significant bit first. After eight accepted bits, the byte is loaded into the byte register (address 0) one cycle after the strobe of the eighth bit. The next byte then starts empty.
- R2: The byte register keeps its value while a later byte is only partly received. It changes only when another byte finishes.
- R3: A finished byte sets status bit 0 (address 1). The bit stays set until software writes a 1 to bit 0 of address 1. If the write-one-to-clear lands in the same cycle as a byte completion, the bit stays set.
- R4: A finished byte equal to match byte A (address 3) or match byte B (address 4) sets status bit 1 at address 1. This bit is sticky and is cleared by writing a 1 to bit 1.
- R5: `intN` is low exactly when (status bit 0 and control bit 1) or (status bit 1 and control bit 2) is true. Control bits are at address 2.
- R6: While control bit 0 (destuffing) is set, a received zero that follows exactly five consecutive received ones is discarded. It does not count toward the byte.
- R7: While destuffing is on, a zero that follows six or more consecutive ones is kept. This covers the flag pattern 0x7E and an abort run of ones.
- R8: While control bit 0 is clear, every received bit is kept.
- R9: After reset, every register reads 0 and `intN` is high. Addresses 5 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Strobe: `bitData` carries one link bit this cycle |
| bitData | input | 1 | Received link bit |
| regAddr | input | 3 | Register address for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| intN | output | 1 | Interrupt, active low |

## Verification
Two events can fall in the same clock cycle: the completion of a byte, and a software write-one-to-clear of the status register. The bench sends seven bits of a byte. It then sends the eighth bit in the same cycle as a write of 1s to the status address. It expects the byte-ready bit to read back as 1 afterwards, because a set must win over a clear. A behavioural model predicts the read data and `intN` on every cycle and also covers this case. Stuffed-zero drops that shift a byte boundary are exercised the same way, with idle gaps between bits.

// File: rtl/fdlRecvPkg.sv
package fdlRecvPkg;

  // Strobes that the control logic sends to the datapath
  typedef struct packed {
    logic shiftEn;   // accept the current bit into the shift register
    logic byteDone;  // the accepted bit completes a byte
  } fdlStrobeT;

  // Register addresses
  localparam int ADDR_BYTE   = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_CTRL   = 2;
  localparam int ADDR_MATCH0 = 3;

  // Status bit positions
  localparam int STAT_FULL  = 0;
  localparam int STAT_MATCH = 1;

  // Control bit positions
  localparam int CTRL_DESTUFF    = 0;
  localparam int CTRL_MASK_FULL  = 1;
  localparam int CTRL_MASK_MATCH = 2;

endpackage

// File: rtl/fdlRecvCtrl.sv
module fdlRecvCtrl
  import fdlRecvPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  localparam int RUN_W    = $clog2(STUFF_RUN + 2),
  localparam int CNT_W    = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic             destuffEn,
  output fdlStrobeT        strobe,
  output logic [RUN_W-1:0] runLen
);

  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             dropZero;

  // A zero after exactly STUFF_RUN ones is a stuffed zero
  assign dropZero        = bitValid && !bitData && destuffEn && (runLen == RUN_STUFF);
  assign strobe.shiftEn  = bitValid && !dropZero;
  assign strobe.byteDone = strobe.shiftEn && (bitCnt == CNT_LAST);

  // Length of the current run of ones, saturating one above the stuffing length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (bitValid) begin
      if (!bitData)              runLen <= '0;
      else if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
    end
  end

  // Counts only the bits that are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      if (strobe.byteDone) bitCnt <= '0;
      else                 bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/fdlRecvPath.sv
module fdlRecvPath
  import fdlRecvPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_MATCH = 2,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fdlStrobeT         strobe,
  input  logic              bitData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              destuffEn,
  output logic              maskFull,
  output logic              maskMatch,
  output logic              statusFull,
  output logic              statusMatch,
  output logic              matchHit,
  output logic [BYTE_W-1:0] readByte,
  output logic              intN
);

  logic [BYTE_W-1:0]    shiftReg;
  logic [BYTE_W-1:0]    nextByte;
  logic [BYTE_W-1:0]    matchReg [NUM_MATCH];
  logic [NUM_MATCH-1:0] hitVec;
  logic                 wrStatus;
  logic                 wrCtrl;

  assign wrStatus = regWrEn && (regAddr == ADDR_W'(ADDR_STATUS));
  assign wrCtrl   = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  // New bits enter at the top, so the first bit of a byte ends at bit 0
  assign nextByte = {bitData, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readByte <= '0;
    end else if (strobe.byteDone) begin
      readByte <= nextByte;
    end
  end

  // One match register and comparator per pattern
  for (genvar g = 0; g < NUM_MATCH; g++) begin : gMatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchReg[g] <= '0;
      end else if (regWrEn && (regAddr == ADDR_W'(ADDR_MATCH0 + g))) begin
        matchReg[g] <= regWrData;
      end
    end
    assign hitVec[g] = (nextByte == matchReg[g]);
  end

  assign matchHit = strobe.byteDone && (|hitVec);

  // Control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destuffEn <= 1'b0;
      maskFull  <= 1'b0;
      maskMatch <= 1'b0;
    end else if (wrCtrl) begin
      destuffEn <= regWrData[CTRL_DESTUFF];
      maskFull  <= regWrData[CTRL_MASK_FULL];
      maskMatch <= regWrData[CTRL_MASK_MATCH];
    end
  end

  // Sticky status bits: a new event takes priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusFull  <= 1'b0;
      statusMatch <= 1'b0;
    end else begin
      statusFull  <= (statusFull  && !(wrStatus && regWrData[STAT_FULL]))  || strobe.byteDone;
      statusMatch <= (statusMatch && !(wrStatus && regWrData[STAT_MATCH])) || matchHit;
    end
  end

  assign intN = !((statusFull && maskFull) || (statusMatch && maskMatch));

  // Read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_BYTE)) begin
      regRdData = readByte;
    end else if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      regRdData[STAT_FULL]  = statusFull;
      regRdData[STAT_MATCH] = statusMatch;
    end else if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdData[CTRL_DESTUFF]    = destuffEn;
      regRdData[CTRL_MASK_FULL]  = maskFull;
      regRdData[CTRL_MASK_MATCH] = maskMatch;
    end
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (regAddr == ADDR_W'(ADDR_MATCH0 + i)) regRdData = matchReg[i];
    end
  end

endmodule

// File: rtl/fdlRecvTop.sv
module fdlRecvTop
  import fdlRecvPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter int NUM_MATCH = 2,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              intN
);

  localparam int RUN_W = $clog2(STUFF_RUN + 2);

  fdlStrobeT         strobe;
  logic [RUN_W-1:0]  runLen;
  logic              destuffEn;
  logic              maskFull;
  logic              maskMatch;
  logic              statusFull;
  logic              statusMatch;
  logic              matchHit;
  logic [BYTE_W-1:0] readByte;

  fdlRecvCtrl #(
    .BYTE_W   (BYTE_W),
    .STUFF_RUN(STUFF_RUN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .bitData  (bitData),
    .destuffEn(destuffEn),
    .strobe   (strobe),
    .runLen   (runLen)
  );

  fdlRecvPath #(
    .BYTE_W   (BYTE_W),
    .NUM_MATCH(NUM_MATCH),
    .ADDR_W   (ADDR_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bitData    (bitData),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .destuffEn  (destuffEn),
    .maskFull   (maskFull),
    .maskMatch  (maskMatch),
    .statusFull (statusFull),
    .statusMatch(statusMatch),
    .matchHit   (matchHit),
    .readByte   (readByte),
    .intN       (intN)
  );

endmodule

// File: rtl/fdlRecvChk.sv
module fdlRecvChk
  import fdlRecvPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter int ADDR_W    = 3,
  localparam int RUN_W    = $clog2(STUFF_RUN + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitValid,
  input logic              bitData,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [BYTE_W-1:0] regWrData,
  input logic              intN,
  input fdlStrobeT         strobe,
  input logic [RUN_W-1:0]  runLen,
  input logic              destuffEn,
  input logic              maskFull,
  input logic              statusFull,
  input logic              statusMatch,
  input logic              matchHit,
  input logic [BYTE_W-1:0] readByte
);

  logic clrFull;
  assign clrFull = regWrEn && (regAddr == ADDR_W'(ADDR_STATUS)) && regWrData[STAT_FULL];

  AST_DONE_ON_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteDone |-> strobe.shiftEn); // R1

  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.byteDone |=> $stable(readByte)); // R2

  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteDone |=> statusFull); // R3

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusFull && !clrFull) |=> statusFull); // R3

  AST_HIT_SETS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> statusMatch); // R4

  AST_INT_FULL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (statusFull && maskFull) |-> !intN); // R5

  AST_INT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!statusFull && !statusMatch) |-> intN); // R5

  AST_STUFF_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitData && destuffEn && runLen == RUN_W'(STUFF_RUN)) |-> !strobe.shiftEn); // R6

  AST_LONG_RUN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitData && runLen > RUN_W'(STUFF_RUN)) |-> strobe.shiftEn); // R7

  AST_RAW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !destuffEn) |-> strobe.shiftEn); // R8

endmodule

bind fdlRecvTop fdlRecvChk #(
  .BYTE_W   (BYTE_W),
  .STUFF_RUN(STUFF_RUN),
  .ADDR_W   (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .bitValid   (bitValid),
  .bitData    (bitData),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .intN       (intN),
  .strobe     (strobe),
  .runLen     (runLen),
  .destuffEn  (destuffEn),
  .maskFull   (maskFull),
  .statusFull (statusFull),
  .statusMatch(statusMatch),
  .matchHit   (matchHit),
  .readByte   (readByte)
);

// File: tb/sim_fdlRecvTop.sv
`timescale 1ns/1ps
module sim_fdlRecvTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitData = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intN;

  always #2 clk = ~clk;

  fdlRecvTop u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .intN(intN)
  );

  // Behavioural reference model
  int         mRun = 0;
  bit         mQ[$];
  logic [7:0] mByte = 0, mMA = 0, mMB = 0;
  logic [2:0] mCfg = 0;
  bit         mFull = 0, mMatch = 0;
  logic [2:0] mAddr = 0;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  int  txRun = 0;
  logic [2:0] rdAddr = 0;
  int  gap = 0;

  function automatic logic [7:0] mRead();
    case (mAddr)
      3'd0: return mByte;
      3'd1: return {6'd0, mMatch, mFull};
      3'd2: return {5'd0, mCfg};
      3'd3: return mMA;
      3'd4: return mMB;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic mInt();
    return !((mFull && mCfg[1]) || (mMatch && mCfg[2]));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One clock: compare the outputs against the model, then drive inputs and advance the model
  task automatic step(input bit v, input bit b, input bit w, input logic [2:0] a, input logic [7:0] d);
    bit drop, doneB, hit;
    logic [7:0] nb;
    @(negedge clk);
    case (mAddr)
      3'd0: chk("R1 byte register", regRdData, mRead());
      3'd1: chk("R3 R4 status register", regRdData, mRead());
      default: chk("R9 register read", regRdData, mRead());
    endcase
    chk("R5 intN", {7'd0, intN}, {7'd0, mInt()});
    bitValid = v; bitData = b; regWrEn = w; regAddr = a; regWrData = d;
    drop  = v && !b && mCfg[0] && (mRun == 5);
    doneB = 0; hit = 0; nb = 0;
    if (v) begin
      if (b) mRun++;
      else   mRun = 0;
    end
    if (v && !drop) begin
      mQ.push_back(b);
      if (mQ.size() == 8) begin
        for (int i = 0; i < 8; i++) nb[i] = mQ[i];
        mQ.delete();
        doneB = 1;
        hit = (nb == mMA) || (nb == mMB);
      end
    end
    if (w) begin
      case (a)
        3'd1: begin
          if (d[0]) mFull = 0;
          if (d[1]) mMatch = 0;
        end
        3'd2: mCfg = d[2:0];
        3'd3: mMA = d;
        3'd4: mMB = d;
        default: ;
      endcase
    end
    if (doneB) begin
      mByte = nb;
      mFull = 1;
      if (hit) mMatch = 1;
    end
    mAddr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, rdAddr, 8'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(0, 0, 1, a, d);
    step(0, 0, 0, rdAddr, 8'd0);
  endtask

  task automatic sendBit(input bit b);
    step(1, b, 0, rdAddr, 8'd0);
    if (gap > 0) idle(gap);
  endtask

  // Transmit with zero stuffing after five ones
  task automatic txStuffed(input logic [7:0] by);
    for (int i = 0; i < 8; i++) begin
      sendBit(by[i]);
      if (by[i]) begin
        txRun++;
        if (txRun == 5) begin
          sendBit(1'b0);
          txRun = 0;
        end
      end else begin
        txRun = 0;
      end
    end
  endtask

  task automatic txRaw(input logic [7:0] by);
    for (int i = 0; i < 8; i++) begin
      sendBit(by[i]);
      if (by[i]) txRun++;
      else       txRun = 0;
    end
  endtask

  // Directed read: select an address and sample the port in the same low phase
  task automatic rdChk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    step(0, 0, 0, a, 8'd0);
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic intChk(input string tag, input logic exp);
    step(0, 0, 0, rdAddr, 8'd0);
    #1;
    chk(tag, {7'd0, intN}, {7'd0, exp});
  endtask

  initial begin
    logic [7:0] lfsr;
    // R9: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a);
      #1;
      chk("R9 reset register value", regRdData, 8'd0);
    end
    chk("R9 reset intN high", {7'd0, intN}, 8'd1);
    regAddr = 0;
    @(negedge clk);
    rstN = 1'b1;

    // Match A = flag, match B = 0xA5, destuff and both masks on
    wr(3'd3, 8'h7E);
    wr(3'd4, 8'hA5);
    wr(3'd2, 8'h07);
    rdChk("R9 control readback", 3'd2, 8'h07);

    // R6: stuffed zero inside 0x3F is removed
    txStuffed(8'h3F);
    idle(1);
    rdChk("R6 destuffed byte", 3'd0, 8'h3F);
    rdChk("R3 full set, no match", 3'd1, 8'h01);
    intChk("R5 intN low on full", 1'b0);
    wr(3'd1, 8'h03);
    rdChk("R3 cleared by write one", 3'd1, 8'h00);
    intChk("R5 intN high after clear", 1'b1);

    // R7 + R4: flag byte kept whole and matches A
    txRaw(8'h7E);
    idle(1);
    rdChk("R7 flag kept", 3'd0, 8'h7E);
    rdChk("R4 match A sets bit 1", 3'd1, 8'h03);

    // R5 masks off, R4 match B
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h01);
    gap = 2;
    txStuffed(8'hA5);
    gap = 0;
    idle(1);
    rdChk("R4 match B sets bit 1", 3'd1, 8'h03);
    intChk("R5 masked flags keep intN high", 1'b1);

    // R2: partial byte leaves the byte register unchanged
    for (int i = 0; i < 4; i++) begin
      sendBit(i[0]);
      txRun = 0;
    end
    rdChk("R2 stable during partial byte", 3'd0, 8'hA5);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    txRun = 0;
    idle(1);
    rdChk("R1 LSB first packing", 3'd0, 8'h0A);

    // R3: completion and clear in the same cycle, set wins
    wr(3'd1, 8'h03);
    for (int i = 0; i < 7; i++) sendBit(1'b0);
    step(1, 1, 1, 3'd1, 8'h03);
    txRun = 1;
    idle(1);
    rdChk("R3 set wins over clear", 3'd1, 8'h01);
    rdChk("R1 byte 0x80", 3'd0, 8'h80);

    // R7: abort run of ones, then a zero is kept
    wr(3'd1, 8'h03);
    txRaw(8'hFF);
    txRaw(8'h00);
    idle(1);
    rdChk("R7 zero after abort kept", 3'd0, 8'h00);

    // R8: destuff off, zero after five ones is kept
    wr(3'd2, 8'h06);
    txRaw(8'h1F);
    idle(1);
    rdChk("R8 raw byte kept", 3'd0, 8'h1F);

    // R6: destuff on, a raw zero after five ones shifts the byte boundary
    wr(3'd2, 8'h07);
    wr(3'd1, 8'h03);
    txRaw(8'h1F);
    idle(1);
    rdChk("R6 dropped zero not counted", 3'd1, 8'h00);
    sendBit(1'b1);
    idle(1);
    rdChk("R6 boundary after drop", 3'd0, 8'h9F);
    txRun = 0;

    // R1: pseudo-random stuffed stream with gaps
    lfsr = 8'h5B;
    for (int n = 0; n < 24; n++) begin
      gap = n % 3;
      txStuffed(lfsr);
      gap = 0;
      idle(1);
      rdChk("R1 stream byte", 3'd0, lfsr);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    idle(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule